// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two component predictors side by side and letting a trained selector pick one of them for each branch. The global component is a table of 2-bit saturating counters addressed by a shift register holding recent branch outcomes. The local component has two levels. A per-branch history table, addressed by PC bits, holds each branch's own recent outcomes. That history then addresses a table of 3-bit saturating counters. A selector table of 2-bit counters, addressed by the global history, decides which component's answer becomes the final prediction.

Fetch presents a PC on the lookup port. In the same cycle the block returns the final prediction, both component predictions, and the two history values that were used as table indices. Fetch keeps these snapshot indices with the branch. When the branch resolves, the resolve port receives its PC, its real outcome and the saved snapshots. The block then trains the counters at those indices, steers the selector if the two components disagreed, and shifts the outcome into the global history and into the branch's local history entry.

Top module: `tourney_bp`

## Requirements
- R1: The final prediction is the global prediction when the selector counter at index global history has value 2 or 3. It is the local prediction when that counter is 0 or 1.
- R2: The global prediction is bit 1 (the MSB) of the 2-bit counter addressed by the current 12-bit global history.
- R3: The local history table entry is chosen by lookup PC bits [11:2]. That 10-bit entry addresses a 3-bit counter, and the local prediction is taken when the counter is 4 or more.
- R4: A valid resolve shifts the global history left by one and places the outcome in bit 0, so bit i holds the outcome of the (i+1)-th most recent resolved branch (1 = taken). Without a resolve the history holds its value. The current value appears on snap_ghist_o.
- R5: A valid resolve shifts its outcome into bit 0 of the local history entry chosen by resolve PC bits [11:2], in the same way as R4. The entry chosen by the lookup PC appears on snap_lhist_o.
- R6: On a valid resolve, the global counter at res_ghist_i and the local counter at res_lhist_i each step up by one when the branch was taken and down by one when it was not. Both saturate: the 2-bit counter at 0 and 3, the 3-bit counter at 0 and 7.
- R7: The selector counter at res_ghist_i changes only when the component predictions read at the snapshot indices disagree. It steps up (toward global) when the global one was correct and down when the local one was correct, saturating at 0 and 3.
- R8: After reset both histories are zero, global counters are 1, local counters are 3 and selector counters are 1 (weakly favour local). So every lookup predicts not taken.
- R9: Lookup outputs depend only on state held before the current clock edge. A resolve in the same cycle affects lookups from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_pc_i | input | PC_W | PC of the branch being predicted |
| pred_taken_o | output | 1 | Final prediction |
| pred_global_o | output | 1 | Global component prediction |
| pred_local_o | output | 1 | Local component prediction |
| snap_ghist_o | output | GH_W | Global history used for this lookup |
| snap_lhist_o | output | LH_W | Local history used for this lookup |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | PC_W | PC of the resolving branch |
| res_taken_i | input | 1 | Actual outcome |
| res_ghist_i | input | GH_W | Global history snapshot saved at lookup |
| res_lhist_i | input | LH_W | Local history snapshot saved at lookup |

## Verification
The assertions take for granted that res_valid_i, res_taken_i and the PCs are never unknown after reset. They also assume that a lookup and a resolve of the same PC in one cycle see the local entry before the update. The bench drives every input at the falling edge with defined values and resolves each branch one cycle after its lookup, using the snapshots it saved. Directed phases also feed chosen snapshot indices, so that saturation, hysteresis and selector steering can be observed through the lookup outputs.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // saturating step of an up/down counter whose top value is maxv
  function automatic logic [7:0] sat_step(logic [7:0] v, logic up, logic [7:0] maxv);
    if (up) return (v == maxv) ? v : v + 8'd1;
    else    return (v == 8'd0) ? v : v - 8'd1;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int ENTRIES = 4096,
  parameter int CW      = 2,
  parameter int RST_VAL = 1,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic [CW-1:0] rd_ctr_o,
  input  logic [IW-1:0] up_idx_i,
  output logic [CW-1:0] up_ctr_o,
  input  logic          up_en_i,
  input  logic          up_inc_i
);
  import tp_pkg::*;
  localparam logic [7:0] MAXV = 8'((1 << CW) - 1);

  logic [CW-1:0] ctr_q [ENTRIES];
  logic [7:0]    nxt;

  assign rd_ctr_o = ctr_q[rd_idx_i];
  assign up_ctr_o = ctr_q[up_idx_i];
  assign nxt      = sat_step(8'(up_ctr_o), up_inc_i, MAXV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CW'(RST_VAL);
    end else if (up_en_i) begin
      ctr_q[up_idx_i] <= nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int ENTRIES = 1024,
  parameter int HW      = 10,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic [HW-1:0] rd_hist_o,
  input  logic          up_en_i,
  input  logic [IW-1:0] up_idx_i,
  input  logic          up_bit_i
);
  logic [HW-1:0] hist_q [ENTRIES];

  assign rd_hist_o = hist_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
    end else if (up_en_i) begin
      hist_q[up_idx_i] <= {hist_q[up_idx_i][HW-2:0], up_bit_i};
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W      = 32,
  parameter int GH_W      = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int LC_W      = 3,
  parameter int GC_W      = 2,
  parameter int SEL_W     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_taken_o,
  output logic            pred_global_o,
  output logic            pred_local_o,
  output logic [GH_W-1:0] snap_ghist_o,
  output logic [LH_W-1:0] snap_lhist_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [GH_W-1:0] res_ghist_i,
  input  logic [LH_W-1:0] res_lhist_i
);
  localparam int G_ENT   = 1 << GH_W;
  localparam int L_ENT   = 1 << LH_W;
  localparam int LHT_ENT = 1 << LHT_IDX_W;
  localparam int G_RST   = (1 << (GC_W - 1)) - 1;   // weakly not taken
  localparam int L_RST   = (1 << (LC_W - 1)) - 1;
  localparam int S_RST   = (1 << (SEL_W - 1)) - 1;  // weakly local

  logic [GH_W-1:0]      ghist_q;
  logic [LHT_IDX_W-1:0] lk_lidx, rs_lidx;
  logic [GC_W-1:0]      g_lk, g_rs;
  logic [LC_W-1:0]      l_lk, l_rs;
  logic [SEL_W-1:0]     s_lk, s_rs;
  logic                 g_rs_pred, l_rs_pred, disagree;

  assign lk_lidx = lookup_pc_i[LHT_IDX_W+1:2];
  assign rs_lidx = res_pc_i[LHT_IDX_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghist_q <= '0;
    else if (res_valid_i) ghist_q <= {ghist_q[GH_W-2:0], res_taken_i};
  end

  tp_hist_table #(.ENTRIES(LHT_ENT), .HW(LH_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (lk_lidx),
    .rd_hist_o(snap_lhist_o),
    .up_en_i  (res_valid_i),
    .up_idx_i (rs_lidx),
    .up_bit_i (res_taken_i)
  );

  tp_ctr_table #(.ENTRIES(G_ENT), .CW(GC_W), .RST_VAL(G_RST)) u_gtab (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist_q),     .rd_ctr_o(g_lk),
    .up_idx_i(res_ghist_i), .up_ctr_o(g_rs),
    .up_en_i (res_valid_i), .up_inc_i(res_taken_i)
  );

  tp_ctr_table #(.ENTRIES(L_ENT), .CW(LC_W), .RST_VAL(L_RST)) u_ltab (
    .clk_i, .rst_ni,
    .rd_idx_i(snap_lhist_o), .rd_ctr_o(l_lk),
    .up_idx_i(res_lhist_i),  .up_ctr_o(l_rs),
    .up_en_i (res_valid_i),  .up_inc_i(res_taken_i)
  );

  assign g_rs_pred = g_rs[GC_W-1];
  assign l_rs_pred = l_rs[LC_W-1];
  assign disagree  = g_rs_pred ^ l_rs_pred;

  tp_ctr_table #(.ENTRIES(G_ENT), .CW(SEL_W), .RST_VAL(S_RST)) u_sel (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist_q),                 .rd_ctr_o(s_lk),
    .up_idx_i(res_ghist_i),             .up_ctr_o(s_rs),
    .up_en_i (res_valid_i && disagree), .up_inc_i(g_rs_pred == res_taken_i)
  );

  assign snap_ghist_o  = ghist_q;
  assign pred_global_o = g_lk[GC_W-1];
  assign pred_local_o  = l_lk[LC_W-1];
  assign pred_taken_o  = s_lk[SEL_W-1] ? pred_global_o : pred_local_o;

  logic unused_sel;
  assign unused_sel = ^s_rs;
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int PC_W      = 32,
  parameter int GH_W      = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lookup_pc_i,
  input logic            pred_taken_o,
  input logic            pred_global_o,
  input logic            pred_local_o,
  input logic [GH_W-1:0] snap_ghist_o,
  input logic [LH_W-1:0] snap_lhist_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_taken_i
);
  logic same_lidx;
  assign same_lidx = res_pc_i[LHT_IDX_W+1:2] == lookup_pc_i[LHT_IDX_W+1:2];

  a_r1_agree_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_global_o == pred_local_o) |-> (pred_taken_o == pred_global_o));

  a_r1_picks_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_taken_o == pred_global_o) || (pred_taken_o == pred_local_o));

  a_r4_ghist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> snap_ghist_o == {$past(snap_ghist_o[GH_W-2:0]), $past(res_taken_i)});

  a_r4_ghist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(snap_ghist_o));

  a_r5_lhist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && same_lidx) |=>
      (!$stable(lookup_pc_i[LHT_IDX_W+1:2]) ||
       snap_lhist_o == {$past(snap_lhist_o[LH_W-2:0]), $past(res_taken_i)}));

  a_r8_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({pred_taken_o, pred_global_o, pred_local_o}));
endmodule

bind tourney_bp tourney_bp_chk #(
  .PC_W(PC_W), .GH_W(GH_W), .LHT_IDX_W(LHT_IDX_W), .LH_W(LH_W)
) u_chk (
  .clk_i, .rst_ni, .lookup_pc_i, .pred_taken_o, .pred_global_o, .pred_local_o,
  .snap_ghist_o, .snap_lhist_o, .res_valid_i, .res_pc_i, .res_taken_i
);

// File: tb/sim_tourney_bp.sv
`timescale 1ns/1ps
module sim_tourney_bp;
  localparam int GH = 12, LH = 10, LI = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] lookup_pc = '0, res_pc = '0;
  logic res_valid = 1'b0, res_taken = 1'b0;
  logic [GH-1:0] res_ghist = '0;
  logic [LH-1:0] res_lhist = '0;
  logic pred_taken, pred_global, pred_local;
  logic [GH-1:0] snap_ghist;
  logic [LH-1:0] snap_lhist;

  always #2.5 clk = ~clk;

  tourney_bp u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_pc_i(lookup_pc),
    .pred_taken_o(pred_taken), .pred_global_o(pred_global), .pred_local_o(pred_local),
    .snap_ghist_o(snap_ghist), .snap_lhist_o(snap_lhist),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_ghist_i(res_ghist), .res_lhist_i(res_lhist)
  );

  // reference model
  logic [1:0]    m_g [1<<GH];
  logic [2:0]    m_l [1<<LH];
  logic [1:0]    m_c [1<<GH];
  logic [LH-1:0] m_lht [1<<LI];
  logic [GH-1:0] m_gh;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int lidx(logic [31:0] pc);
    return int'(pc[LI+1:2]);
  endfunction

  function automatic logic [7:0] sat(logic [7:0] v, logic up, logic [7:0] mx);
    if (up) return (v == mx) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1<<GH); i++) begin m_g[i] = 2'd1; m_c[i] = 2'd1; end
    for (int i = 0; i < (1<<LH); i++) m_l[i] = 3'd3;
    for (int i = 0; i < (1<<LI); i++) m_lht[i] = '0;
    m_gh = '0;
  endtask

  task automatic model_update(logic [31:0] pc, logic t, logic [GH-1:0] g, logic [LH-1:0] l);
    logic gp, lp;
    gp = m_g[g][1];
    lp = m_l[l][2];
    m_g[g] = 2'(sat(8'(m_g[g]), t, 8'd3));
    m_l[l] = 3'(sat(8'(m_l[l]), t, 8'd7));
    if (gp != lp) m_c[g] = 2'(sat(8'(m_c[g]), gp == t, 8'd3));
    m_gh = {m_gh[GH-2:0], t};
    m_lht[lidx(pc)] = {m_lht[lidx(pc)][LH-2:0], t};
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(logic [31:0] pc, string ph);
    logic [LH-1:0] lh;
    logic gp, lp;
    lh = m_lht[lidx(pc)];
    gp = m_g[m_gh][1];
    lp = m_l[lh][2];
    chk({"R4 snap_ghist ", ph}, 32'(snap_ghist), 32'(m_gh));
    chk({"R5 snap_lhist ", ph}, 32'(snap_lhist), 32'(lh));
    chk({"R2 pred_global ", ph}, 32'(pred_global), 32'(gp));
    chk({"R3 pred_local ", ph}, 32'(pred_local), 32'(lp));
    chk({"R1 pred_taken ", ph}, 32'(pred_taken), 32'(m_c[m_gh][1] ? gp : lp));
  endtask

  // one cycle: drive at falling edge, check, model follows the rising edge
  task automatic step(logic [31:0] pc, logic rv, logic [31:0] rpc, logic rt,
                      logic [GH-1:0] rg, logic [LH-1:0] rl, string ph);
    @(negedge clk);
    lookup_pc = pc; res_valid = rv; res_pc = rpc; res_taken = rt;
    res_ghist = rg; res_lhist = rl;
    #1 check_all(pc, ph);
    @(posedge clk);
    if (rv) model_update(rpc, rt, rg, rl);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; res_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // resolve pc in the same cycle it is looked up, with the live snapshot
  task automatic run_branch(logic [31:0] pc, logic t, string ph);
    step(pc, 1'b1, pc, t, m_gh, m_lht[lidx(pc)], ph);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcs [16];
    int cnt [16];
    void'($urandom(32'd5150));
    model_reset();
    do_reset();

    // R8: reset state, everything predicts not taken
    @(negedge clk); lookup_pc = 32'h0000_1234; #1;
    chk("R8 reset ghist", 32'(snap_ghist), 0);
    chk("R8 reset lhist", 32'(snap_lhist), 0);
    chk("R8 reset global", 32'(pred_global), 0);
    chk("R8 reset local", 32'(pred_local), 0);
    chk("R8 reset final", 32'(pred_taken), 0);

    // R7: agreeing resolve leaves selector alone, disagreeing one steers it to global
    step(32'h0000_0000, 1'b1, 32'h0000_0FC0, 1'b1, 12'h000, 10'h005, "R7 agree");
    step(32'h0000_0000, 1'b1, 32'h0000_0FC0, 1'b1, 12'h000, 10'h009, "R7 disagree");
    for (int i = 0; i < 12; i++)
      step(32'h0000_0000, 1'b1, 32'h0000_0FC0, 1'b0, 12'hABC, 10'h111, "R7 flush");
    @(negedge clk); lookup_pc = 32'h0000_0000; res_valid = 1'b0; #1;
    chk("R7 ghist back to zero", 32'(snap_ghist), 0);
    chk("R7 local says not taken", 32'(pred_local), 0);
    chk("R7 global says taken", 32'(pred_global), 1);
    chk("R7 selector now global", 32'(pred_taken), 1);

    // R6: saturation and hysteresis on one branch
    do_reset();
    for (int i = 0; i < 30; i++) run_branch(32'h0000_2040, 1'b1, "R6 sat");
    @(negedge clk); lookup_pc = 32'h0000_2040; res_valid = 1'b0; #1;
    chk("R6 global saturated taken", 32'(pred_global), 1);
    chk("R6 local saturated taken", 32'(pred_local), 1);
    run_branch(32'h0000_2040, 1'b0, "R6 miss");
    for (int i = 0; i < 12; i++) run_branch(32'h0000_2040, 1'b1, "R6 refill");
    @(negedge clk); lookup_pc = 32'h0000_2040; res_valid = 1'b0; #1;
    chk("R6 global keeps taken after one miss", 32'(pred_global), 1);
    chk("R6 local keeps taken", 32'(pred_local), 1);
    check_all(32'h0000_2040, "R6 end");

    // R9: same-cycle resolve does not affect the lookup in that cycle
    @(negedge clk);
    lookup_pc = 32'h0000_3000; res_valid = 1'b1; res_pc = 32'h0000_3000; res_taken = 1'b1;
    res_ghist = m_gh; res_lhist = m_lht[lidx(32'h0000_3000)];
    #1;
    chk("R9 lhist pre-update", 32'(snap_lhist), 32'(m_lht[lidx(32'h0000_3000)]));
    chk("R9 ghist pre-update", 32'(snap_ghist), 32'(m_gh));
    @(posedge clk);
    model_update(32'h0000_3000, 1'b1, res_ghist, res_lhist);
    @(negedge clk); res_valid = 1'b0; #1;
    chk("R9 lhist after edge", 32'(snap_lhist), 32'(m_lht[lidx(32'h0000_3000)]));
    chk("R4 ghist after edge", 32'(snap_ghist), 32'(m_gh));

    // random mix: resolve previous lookup one cycle later
    do_reset();
    for (int k = 0; k < 16; k++) begin pcs[k] = 32'h0001_0000 + k * 32'd148; cnt[k] = 0; end
    begin
      bit pv = 0;
      int pk = 0;
      logic [GH-1:0] pg = '0;
      logic [LH-1:0] pl = '0;
      for (int n = 0; n < 4000; n++) begin
        int k;
        bit rv, t;
        logic [GH-1:0] sg;
        logic [LH-1:0] sl;
        k = int'($urandom % 16);
        rv = pv && ($urandom % 5 != 0);
        t = 1'b0;
        if (rv) begin
          case (pk % 3)
            0: t = (cnt[pk] % (pk + 3)) != (pk + 2);
            1: t = ($urandom % 100) < 85;
            default: t = m_gh[0] ^ pk[0];
          endcase
          cnt[pk]++;
        end
        sg = m_gh;
        sl = m_lht[lidx(pcs[k])];
        step(pcs[k], rv, pcs[pk], t, pg, pl, "rand");
        pv = 1; pk = k; pg = sg; pl = sl;
      end
    end
    @(negedge clk); res_valid = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule